// File: doc/BRIEF.md
# Three-Sequence Update Session Controller

This block steers a one-way firmware update session. It receives already decrypted 16-byte blocks, one per `blk_valid` pulse, and walks through three chained sequences in a fixed order: an authentication sequence, an EEPROM data sequence and a flash data sequence. No length field and no command codes exist in the stream. The first block of each sequence is stored as that sequence's end marker, and the sequence closes when the same 128-bit pattern arrives again. Every block in between is payload. It becomes an EEPROM write, or flash buffer fills with page writes, depending on the sequence.

The controller only drives command pulses. The memories and the cipher sit outside it. The first flash payload block erases the application flash. A page write follows each full page of gathered blocks. When the last flash marker is recognised the controller starts the application. A timeout during authentication also hands over to the application, so that line noise after power-up never blocks the device. Once authentication has passed, a timeout blocks the controller until reset. If flash was already touched, a full emergency erase is issued first.

Top module: `us_session_ctrl`

## Requirements
- R1: The first block of each sequence is held as its marker, and every later block is compared with it over all 128 bits. A block that differs from the marker in a single bit of any byte (bytes 0 to 15) is payload, not an end.
- R2: Sequences advance only in the order authentication, EEPROM, flash. A marker match closes the current sequence, and the next block is the head of the following one.
- R3: While authentication is in progress, `ee_we`, `fl_fill`, `fl_erase` and `fl_page_wr` all stay low, including for non-matching blocks.
- R4: Each EEPROM payload block raises `ee_we` for one cycle, in the cycle after its `blk_valid`. `ee_addr` starts at 0 and grows by 16 per block, and `wr_data` carries the block. An EEPROM sequence with no payload raises no `ee_we`.
- R5: Each flash payload block raises `fl_fill` for one cycle after its `blk_valid`, with `fl_addr` starting at 0 and growing by 16. `fl_erase` is high together with the first fill only. A flash sequence with no payload raises neither.
- R6: `fl_page_wr` is high in the cycle after the fill that completes a page of `PAGE_BYTES`, where the block address has all bits from 4 up to log2(`PAGE_BYTES`)-1 set. `fl_page_addr` is that page's base address, and no page write ever comes before the erase.
- R7: A `timeout` pulse during authentication (head or body) sets `app_go` from the next cycle on.
- R8: A `timeout` during the EEPROM sequence, or during the flash sequence before any fill, sets `locked` from the next cycle on, without `fl_wipe`.
- R9: A `timeout` after the flash erase drives `fl_wipe` high for exactly one cycle, and `locked` follows in the next cycle.
- R10: Once `app_go` or `locked` is set it stays set until reset, and later blocks or timeouts cause no command pulse.
- R11: The match of the flash marker sets `app_go` in the cycle after that block's `blk_valid`.
- R12: After reset all outputs are low, and `ee_addr` and `fl_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | One-cycle strobe for a decrypted block |
| blk_data | input | 128 | Decrypted block |
| timeout | input | 1 | One-cycle pulse from the external inactivity timer |
| ee_we | output | 1 | EEPROM 16-byte write command |
| ee_addr | output | EE_AW | EEPROM byte address of the write |
| wr_data | output | 128 | Block data for EEPROM write or flash fill |
| fl_erase | output | 1 | Application flash erase command |
| fl_fill | output | 1 | Flash page buffer fill command |
| fl_addr | output | FL_AW | Flash byte address of the fill |
| fl_page_wr | output | 1 | Flash page write command |
| fl_page_addr | output | FL_AW | Base byte address of the written page |
| fl_wipe | output | 1 | Emergency full flash erase command |
| app_go | output | 1 | Application start (held) |
| locked | output | 1 | Blocking state (held until reset) |

## Verification
The assertions take `blk_valid` and `timeout` to be single-cycle pulses, and they take a correct session to carry payload blocks that never equal their sequence's marker by accident. The bench keeps to this. It drives each block for one cycle, leaves at least one idle cycle between blocks, and makes the marker patterns byte-repeated values while payload words carry a counter. The near-miss payloads that differ from a marker by one bit are the only blocks meant to resemble a marker.

// File: rtl/us_pkg.sv
package us_pkg;

    localparam int BLK_BYTES = 16;
    localparam int BLK_BITS  = BLK_BYTES * 8;
    localparam int BLK_SHIFT = $clog2(BLK_BYTES);

    typedef logic [BLK_BITS-1:0] blk_t;

    typedef enum logic [3:0] {
        ST_AUTH_HEAD,
        ST_AUTH_BODY,
        ST_EE_HEAD,
        ST_EE_BODY,
        ST_FL_HEAD,
        ST_FL_BODY,
        ST_RUN,
        ST_WIPE,
        ST_LOCK
    } state_e;

    // Per-block decision of the sequencer
    typedef struct packed {
        logic   mark_load;
        logic   ee_do;
        logic   fl_do;
        state_e nxt;
    } step_t;

    function automatic logic in_auth(state_e s);
        return (s == ST_AUTH_HEAD) || (s == ST_AUTH_BODY);
    endfunction

    function automatic logic is_head(state_e s);
        return (s == ST_AUTH_HEAD) || (s == ST_EE_HEAD) || (s == ST_FL_HEAD);
    endfunction

    // Body state that follows a head state
    function automatic state_e body_of(state_e s);
        case (s)
            ST_AUTH_HEAD: return ST_AUTH_BODY;
            ST_EE_HEAD:   return ST_EE_BODY;
            default:      return ST_FL_BODY;
        endcase
    endfunction

    // State entered when a body state sees its marker again
    function automatic state_e after_match(state_e s);
        case (s)
            ST_AUTH_BODY: return ST_EE_HEAD;
            ST_EE_BODY:   return ST_FL_HEAD;
            default:      return ST_RUN;
        endcase
    endfunction

endpackage

// File: rtl/us_marker.sv
// Holds the first block of a sequence and compares incoming blocks with it.
module us_marker
    import us_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  blk_t blk,
    output logic hit
);

    blk_t                 mark_q;
    logic [BLK_BYTES-1:0] byte_eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= '0;
        end else if (load) begin
            mark_q <= blk;
        end
    end

    // One comparator per byte lane, reduced into a single hit
    generate
        for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
            assign byte_eq[g] = (mark_q[g*8 +: 8] == blk[g*8 +: 8]);
        end
    endgenerate

    assign hit = &byte_eq;

endmodule

// File: rtl/us_flash_track.sv
// Flash block address counter with page-boundary detection.
module us_flash_track
    import us_pkg::*;
#(
    parameter int FL_AW      = 13,
    parameter int PAGE_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [FL_AW-1:0] addr,
    output logic             page_end
);

    localparam int PG_LSB = $clog2(PAGE_BYTES);
    localparam int IDX_W  = FL_AW - BLK_SHIFT;

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign addr = {idx_q, {BLK_SHIFT{1'b0}}};

    generate
        if (PG_LSB == BLK_SHIFT) begin : g_one_blk_page
            assign page_end = 1'b1;
        end else begin : g_multi_blk_page
            assign page_end = &idx_q[PG_LSB-BLK_SHIFT-1:0];
        end
    endgenerate

endmodule

// File: rtl/us_fsm.sv
// Session sequencer: sequence order, command pulses, timeout policy.
module us_fsm
    import us_pkg::*;
#(
    parameter int EE_AW      = 10,
    parameter int FL_AW      = 13,
    parameter int PAGE_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_valid,
    input  blk_t             blk,
    input  logic             timeout,
    input  logic             hit,
    input  logic [FL_AW-1:0] fl_addr_in,
    input  logic             page_end,
    output state_e           st,
    output logic             mark_load,
    output logic             fl_step,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_addr,
    output blk_t             wr_data,
    output logic             fl_erase,
    output logic             fl_fill,
    output logic [FL_AW-1:0] fl_addr,
    output logic             fl_page_wr,
    output logic [FL_AW-1:0] fl_page_addr,
    output logic             fl_wipe,
    output logic             app_go,
    output logic             locked
);

    localparam logic [EE_AW-1:0] EE_STEP = EE_AW'(BLK_BYTES);
    localparam logic [FL_AW-1:0] PG_MASK = FL_AW'(PAGE_BYTES - 1);

    state_e           st_q;
    step_t            dec;
    logic             touched_q;
    logic [EE_AW-1:0] ee_ptr_q;
    logic             pend_q;
    logic [FL_AW-1:0] pend_addr_q;

    logic             ee_we_q, fl_fill_q, fl_erase_q, fl_page_q;
    logic [EE_AW-1:0] ee_addr_q;
    logic [FL_AW-1:0] fl_addr_q, fl_page_addr_q;
    blk_t             wr_data_q;

    // Next-state and per-block decision
    always_comb begin
        dec           = '0;
        dec.nxt       = st_q;
        unique case (st_q)
            ST_AUTH_HEAD, ST_EE_HEAD, ST_FL_HEAD: begin
                if (timeout) begin
                    dec.nxt = in_auth(st_q) ? ST_RUN : ST_LOCK;
                end else if (blk_valid) begin
                    dec.mark_load = 1'b1;
                    dec.nxt       = body_of(st_q);
                end
            end
            ST_AUTH_BODY, ST_EE_BODY, ST_FL_BODY: begin
                if (timeout) begin
                    if (in_auth(st_q)) begin
                        dec.nxt = ST_RUN;
                    end else if (touched_q) begin
                        dec.nxt = ST_WIPE;
                    end else begin
                        dec.nxt = ST_LOCK;
                    end
                end else if (blk_valid) begin
                    if (hit) begin
                        dec.nxt = after_match(st_q);
                    end else if (st_q == ST_EE_BODY) begin
                        dec.ee_do = 1'b1;
                    end else if (st_q == ST_FL_BODY) begin
                        dec.fl_do = 1'b1;
                    end
                end
            end
            ST_WIPE: dec.nxt = ST_LOCK;
            default: dec.nxt = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= ST_AUTH_HEAD;
            touched_q      <= 1'b0;
            ee_ptr_q       <= '0;
            pend_q         <= 1'b0;
            pend_addr_q    <= '0;
            ee_we_q        <= 1'b0;
            fl_fill_q      <= 1'b0;
            fl_erase_q     <= 1'b0;
            fl_page_q      <= 1'b0;
            ee_addr_q      <= '0;
            fl_addr_q      <= '0;
            fl_page_addr_q <= '0;
            wr_data_q      <= '0;
        end else begin
            st_q       <= dec.nxt;
            ee_we_q    <= dec.ee_do;
            fl_fill_q  <= dec.fl_do;
            fl_erase_q <= dec.fl_do & ~touched_q;
            if (dec.fl_do) begin
                touched_q   <= 1'b1;
                fl_addr_q   <= fl_addr_in;
                pend_addr_q <= fl_addr_in & ~PG_MASK;
            end
            if (dec.ee_do) begin
                ee_addr_q <= ee_ptr_q;
                ee_ptr_q  <= ee_ptr_q + EE_STEP;
            end
            if (dec.ee_do || dec.fl_do) begin
                wr_data_q <= blk;
            end
            // Page write trails the completing fill by one cycle, so it
            // always lands after the erase; a timeout cancels it.
            pend_q         <= dec.fl_do & page_end;
            fl_page_q      <= pend_q & ~timeout;
            fl_page_addr_q <= pend_addr_q;
        end
    end

    assign st           = st_q;
    assign mark_load    = dec.mark_load;
    assign fl_step      = dec.fl_do;
    assign ee_we        = ee_we_q;
    assign ee_addr      = ee_addr_q;
    assign wr_data      = wr_data_q;
    assign fl_erase     = fl_erase_q;
    assign fl_fill      = fl_fill_q;
    assign fl_addr      = fl_addr_q;
    assign fl_page_wr   = fl_page_q;
    assign fl_page_addr = fl_page_addr_q;
    assign fl_wipe      = (st_q == ST_WIPE);
    assign app_go       = (st_q == ST_RUN);
    assign locked       = (st_q == ST_LOCK);

endmodule

// File: rtl/us_session_ctrl.sv
// Top: three-sequence update session controller.
module us_session_ctrl
    import us_pkg::*;
#(
    parameter int EE_AW      = 10,
    parameter int FL_AW      = 13,
    parameter int PAGE_BYTES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                blk_valid,
    input  logic [BLK_BITS-1:0] blk_data,
    input  logic                timeout,
    output logic                ee_we,
    output logic [EE_AW-1:0]    ee_addr,
    output logic [BLK_BITS-1:0] wr_data,
    output logic                fl_erase,
    output logic                fl_fill,
    output logic [FL_AW-1:0]    fl_addr,
    output logic                fl_page_wr,
    output logic [FL_AW-1:0]    fl_page_addr,
    output logic                fl_wipe,
    output logic                app_go,
    output logic                locked
);

    state_e           st;
    logic             mark_load;
    logic             hit;
    logic             fl_step;
    logic [FL_AW-1:0] fl_cur;
    logic             page_end;

    us_marker u_marker (
        .clk  (clk),
        .rst  (rst),
        .load (mark_load),
        .blk  (blk_data),
        .hit  (hit)
    );

    us_flash_track #(
        .FL_AW      (FL_AW),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .step     (fl_step),
        .addr     (fl_cur),
        .page_end (page_end)
    );

    us_fsm #(
        .EE_AW      (EE_AW),
        .FL_AW      (FL_AW),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .blk_valid    (blk_valid),
        .blk          (blk_data),
        .timeout      (timeout),
        .hit          (hit),
        .fl_addr_in   (fl_cur),
        .page_end     (page_end),
        .st           (st),
        .mark_load    (mark_load),
        .fl_step      (fl_step),
        .ee_we        (ee_we),
        .ee_addr      (ee_addr),
        .wr_data      (wr_data),
        .fl_erase     (fl_erase),
        .fl_fill      (fl_fill),
        .fl_addr      (fl_addr),
        .fl_page_wr   (fl_page_wr),
        .fl_page_addr (fl_page_addr),
        .fl_wipe      (fl_wipe),
        .app_go       (app_go),
        .locked       (locked)
    );

endmodule

// File: rtl/us_session_chk.sv
// Protocol checker, bound to the top module.
module us_session_chk
    import us_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input state_e st,
    input logic   timeout,
    input logic   ee_we,
    input logic   fl_fill,
    input logic   fl_erase,
    input logic   fl_page_wr,
    input logic   fl_wipe,
    input logic   app_go,
    input logic   locked
);

    logic erase_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            erase_seen_q <= 1'b0;
        end else if (fl_erase) begin
            erase_seen_q <= 1'b1;
        end
    end

    // R3: no memory command while authentication is open
    a_r3_quiet_in_auth: assert property (@(posedge clk) disable iff (rst)
        in_auth(st) |-> !(ee_we || fl_fill || fl_erase || fl_page_wr));

    // R2: a block is routed to one memory only
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ee_we, fl_fill}));

    // R5: erase only together with a fill
    a_r5_erase_with_fill: assert property (@(posedge clk) disable iff (rst)
        fl_erase |-> fl_fill);

    // R6: page write trails a fill and never precedes the erase
    a_r6_page_after_fill: assert property (@(posedge clk) disable iff (rst)
        fl_page_wr |-> $past(fl_fill));

    a_r6_page_after_erase: assert property (@(posedge clk) disable iff (rst)
        fl_page_wr |-> erase_seen_q);

    // R7: timeout in authentication hands over
    a_r7_auth_handover: assert property (@(posedge clk) disable iff (rst)
        (in_auth(st) && timeout) |=> app_go);

    // R9: wipe is followed by the lock state
    a_r9_wipe_then_lock: assert property (@(posedge clk) disable iff (rst)
        fl_wipe |=> locked);

    // R10: terminal states hold and stay silent
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r10_run_sticky: assert property (@(posedge clk) disable iff (rst)
        app_go |=> app_go);

    a_r10_lock_silent: assert property (@(posedge clk) disable iff (rst)
        locked |-> !(ee_we || fl_fill || fl_erase || fl_wipe));

endmodule

bind us_session_ctrl us_session_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .timeout    (timeout),
    .ee_we      (ee_we),
    .fl_fill    (fl_fill),
    .fl_erase   (fl_erase),
    .fl_page_wr (fl_page_wr),
    .fl_wipe    (fl_wipe),
    .app_go     (app_go),
    .locked     (locked)
);

// File: tb/sim_us_session_ctrl.sv
`timescale 1ns/1ps
module sim_us_session_ctrl;

    localparam int EE_AW      = 10;
    localparam int FL_AW      = 13;
    localparam int PAGE_BYTES = 32;
    localparam int BPP        = PAGE_BYTES / 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         blk_valid = 1'b0;
    logic [127:0] blk_data = '0;
    logic         timeout = 1'b0;
    logic             ee_we;
    logic [EE_AW-1:0] ee_addr;
    logic [127:0]     wr_data;
    logic             fl_erase, fl_fill, fl_page_wr, fl_wipe, app_go, locked;
    logic [FL_AW-1:0] fl_addr, fl_page_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [127:0] MA = {16{8'hA1}};
    localparam logic [127:0] ME = {16{8'hB2}};
    localparam logic [127:0] MF = {16{8'hC3}};

    always #2.5 clk = ~clk;

    us_session_ctrl #(.EE_AW(EE_AW), .FL_AW(FL_AW), .PAGE_BYTES(PAGE_BYTES)) u0 (
        .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_data(blk_data),
        .timeout(timeout), .ee_we(ee_we), .ee_addr(ee_addr), .wr_data(wr_data),
        .fl_erase(fl_erase), .fl_fill(fl_fill), .fl_addr(fl_addr),
        .fl_page_wr(fl_page_wr), .fl_page_addr(fl_page_addr),
        .fl_wipe(fl_wipe), .app_go(app_go), .locked(locked)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] payload(input int seq, input int i);
        return {32'hD00D_0000 + 32'(seq), 32'h1357_9BDF, 32'(i * 7 + 3), 32'(i)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one block; returns at the negedge where its pulses are visible
    task automatic send(input logic [127:0] b);
        @(negedge clk);
        blk_valid = 1'b1;
        blk_data  = b;
        @(negedge clk);
        blk_valid = 1'b0;
        blk_data  = '0;
    endtask

    task automatic tmo();
        @(negedge clk);
        timeout = 1'b1;
        @(negedge clk);
        timeout = 1'b0;
    endtask

    task automatic quiet(input string req);
        check(req, {124'd0, ee_we, fl_fill, fl_erase, fl_page_wr}, '0);
    endtask

    task automatic pass_auth();
        send(MA);       quiet("R3 auth head");
        send(~MA);      quiet("R3 auth junk");
        send(MA ^ 128'h1); quiet("R3 auth near miss");
        send(MA);       quiet("R3 auth close");
    endtask

    task automatic run_session(input int ne, input int nf);
        do_reset();
        pass_auth();
        send(ME);
        check("R2 ee head quiet", {127'd0, ee_we}, '0);
        for (int i = 0; i < ne; i++) begin
            send(payload(1, i));
            check("R4 ee_we", {127'd0, ee_we}, 128'd1);
            check("R4 ee_addr", 128'(ee_addr), 128'(16 * i));
            check("R4 wr_data", wr_data, payload(1, i));
            check("R2 not flash", {127'd0, fl_fill}, '0);
        end
        send(ME);
        check("R4 ee close no write", {127'd0, ee_we}, '0);
        send(MF);
        quiet("R5 flash head quiet");
        for (int i = 0; i < nf; i++) begin
            send(payload(2, i));
            check("R5 fl_fill", {127'd0, fl_fill}, 128'd1);
            check("R5 fl_erase", {127'd0, fl_erase}, 128'(i == 0));
            check("R5 fl_addr", 128'(fl_addr), 128'(16 * i));
            check("R5 wr_data", wr_data, payload(2, i));
            check("R6 no page with fill", {127'd0, fl_page_wr}, '0);
            @(negedge clk);
            check("R6 fl_page_wr", {127'd0, fl_page_wr}, 128'((i % BPP) == BPP - 1));
            if ((i % BPP) == BPP - 1)
                check("R6 fl_page_addr", 128'(fl_page_addr), 128'(PAGE_BYTES * (i / BPP)));
            check("R11 not yet running", {127'd0, app_go}, '0);
        end
        send(MF);
        quiet("R5 flash close quiet");
        check("R11 app_go", {127'd0, app_go}, 128'd1);
        check("R11 not locked", {127'd0, locked}, '0);
        send(payload(3, 0));
        quiet("R10 after run");
        tmo();
        check("R10 run holds", {126'd0, app_go, locked}, 128'b10);
    endtask

    initial begin
        do_reset();
        check("R12 reset pulses", {124'd0, ee_we, fl_fill, fl_erase, fl_page_wr}, '0);
        check("R12 reset levels", {125'd0, fl_wipe, app_go, locked}, '0);
        check("R12 reset addr", {100'd0, 18'(ee_addr), 10'd0}, '0);
        check("R12 reset fl_addr", 128'(fl_addr), '0);

        // Sweep payload counts
        for (int ne = 0; ne < 4; ne++)
            for (int nf = 0; nf < 6; nf++)
                run_session(ne, nf);

        // R1: one-bit differences in every byte lane are payload
        do_reset();
        pass_auth();
        send(ME);
        for (int b = 0; b < 16; b++) begin
            send(ME ^ (128'h1 << (8 * b + (b % 8))));
            check("R1 near miss writes", {127'd0, ee_we}, 128'd1);
            check("R1 near miss addr", 128'(ee_addr), 128'(16 * b));
        end
        send(ME);
        check("R1 exact match ends", {127'd0, ee_we}, '0);
        send(MF);
        send(MF);
        check("R2 empty flash ends session", {127'd0, app_go}, 128'd1);

        // R7: timeout in auth head and auth body
        do_reset();
        tmo();
        check("R7 head handover", {126'd0, app_go, locked}, 128'b10);
        send(MA);
        check("R10 ignores after handover", {126'd0, app_go, locked}, 128'b10);
        do_reset();
        send(MA);
        send(payload(0, 1));
        tmo();
        check("R7 body handover", {126'd0, app_go, locked}, 128'b10);

        // R8: timeout in EEPROM sequence
        do_reset();
        pass_auth();
        send(ME);
        send(payload(1, 0));
        tmo();
        check("R8 ee lock", {125'd0, fl_wipe, app_go, locked}, 128'b001);
        @(negedge clk);
        check("R8 ee lock holds", {125'd0, fl_wipe, app_go, locked}, 128'b001);

        // R8: timeout in flash head, untouched
        do_reset();
        pass_auth();
        send(ME); send(ME); send(MF);
        tmo();
        check("R8 flash untouched lock", {125'd0, fl_wipe, app_go, locked}, 128'b001);

        // R9: timeout after erase
        do_reset();
        pass_auth();
        send(ME); send(ME); send(MF);
        send(payload(2, 0));
        check("R9 erase issued", {127'd0, fl_erase}, 128'd1);
        @(negedge clk);
        tmo();
        check("R9 wipe", {125'd0, fl_wipe, app_go, locked}, 128'b100);
        @(negedge clk);
        check("R9 then lock", {125'd0, fl_wipe, app_go, locked}, 128'b001);
        send(MF);
        quiet("R10 locked silent");
        check("R10 lock holds", {125'd0, fl_wipe, app_go, locked}, 128'b001);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule